// File: doc/BRIEF.md
# Wilton Routing Switch Box

This block sits at the crossing point of a horizontal and a vertical routing channel in a programmable logic fabric. Each of the four sides (north, east, south, west) carries `W` single-bit tracks. A signal arriving on any track of one side can be steered onto a track of each of the other three sides: straight across, or turned toward either neighbouring side. Turning connections follow a Wilton track permutation, in which a turn rotates or mirrors the track index. The result is that a net changing direction more than once can reach many more tracks than a pattern that keeps track i on track i.

Every possible connection has its own enable bit. The model replaces each pass connection with a directional driver. Each output track is the OR of the enabled sources aimed at it, so the routing path is purely combinational. The enable bits sit in a small byte-addressed store. It is written synchronously through a byte-wide port and can be read back at any time, so that configuration data can be checked after loading.

Sides are numbered in the cyclic order N=0, E=1, S=2, W=3. For an output on side d, the *following* side is (d+1) mod 4 and the *preceding* side is (d+3) mod 4.

Top module: `swbox_wilton`

## Requirements
- R1: While `rst_n` is low at a clock edge, every enable bit is cleared. After reset, every readback byte is 0x00 and every output track is 0, whatever the input tracks carry.
- R2: Output track t on side d owns configuration nibble n = d*W + t. That nibble is held in byte n/2, in bits [3:0] when n is even and in bits [7:4] when n is odd. With W = 4 there are 8 bytes at addresses 0 to 7.
- R3: Bit 0 of the nibble for output (d, t) connects input track t of the opposite side (d+2) mod 4.
- R4: Bit 1 of the nibble for output (d, t) connects input track (t+W-1) mod W of the following side. An input track i therefore lands on output track (i+1) mod W. For example, with W = 4, east track 3 reaches north track 0.
- R5: Bit 2 of the nibble for output (d, t) connects input track (W-t) mod W of the preceding side. An input track i therefore lands on output track (W-i) mod W. For example, west track 3 reaches north track 1, and track 0 reaches track 0.
- R6: Each output track is the logical OR of the inputs selected by its set enable bits. It is 0 when no enable bit is set or when all selected inputs are 0.
- R7: Bits 3 and 7 of every byte are reserved. Values written to them are discarded, and they read back as 0.
- R8: `cfg_rdata` shows, in the same cycle, the stored byte at `cfg_addr`, including any write taken at the previous clock edge.
- R9: A byte changes only at a clock edge where `rst_n` and `cfg_we` are both high, and only the byte at `cfg_addr` changes.
- R10: Routing is combinational. A change on an input track reaches the enabled output tracks within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset; clears all enables |
| cfg_we | input | 1 | Write strobe for the configuration byte at `cfg_addr` |
| cfg_addr | input | $clog2(2*W) | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the byte at `cfg_addr` |
| trk_in_n | input | W | Tracks arriving on the north side |
| trk_in_e | input | W | Tracks arriving on the east side |
| trk_in_s | input | W | Tracks arriving on the south side |
| trk_in_w | input | W | Tracks arriving on the west side |
| trk_out_n | output | W | Tracks driven out of the north side |
| trk_out_e | output | W | Tracks driven out of the east side |
| trk_out_s | output | W | Tracks driven out of the south side |
| trk_out_w | output | W | Tracks driven out of the west side |

## Verification
The bench targets the wrap-around ends of the track permutation: track W-1 turning onto track 0, and track 0 mirroring onto itself. A design with an off-by-one in either rule would light the wrong track or none. It sets two enables on one output at once to confirm OR merging, where a priority or last-one-wins mux would drop a source. It also writes ones into the reserved bit positions and writes odd and even nibbles of a shared byte. A store that kept reserved bits, or that decoded the nibble half backwards, would read back wrongly or route the neighbouring track. Every cycle, outputs and readback are compared against a behavioural model that scans sources forward, the opposite direction from the hardware's per-output view.

// File: rtl/swbox_pkg.sv
package swbox_pkg;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    localparam int NSIDES = 4;
    localparam int NSRC   = 3;   // enable bits used per output track
    localparam int NIB_W  = 4;   // nibble per output track, top bit reserved

    // Side feeding enable bit k of an output on side d.
    function automatic int src_side(input int k, input int d);
        case (k)
            0:       return (d + 2) % NSIDES;  // straight across
            1:       return (d + 1) % NSIDES;  // following side
            default: return (d + 3) % NSIDES;  // preceding side
        endcase
    endfunction

    // Track on that side feeding enable bit k of output track t.
    function automatic int src_track(input int k, input int t, input int w);
        case (k)
            0:       return t;
            1:       return (t + w - 1) % w;
            default: return (w - t) % w;
        endcase
    endfunction

endpackage

// File: rtl/swbox_cfg_store.sv
module swbox_cfg_store #(
    parameter int W      = 4,
    parameter int NBYTES = 2 * W,
    parameter int AW     = 3
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cfg_we,
    input  logic [AW-1:0]                              cfg_addr,
    input  logic [7:0]                                 cfg_wdata,
    output logic [7:0]                                 cfg_rdata,
    output logic [swbox_pkg::NSIDES*W-1:0][swbox_pkg::NSRC-1:0] en
);
    localparam int        NTRK      = swbox_pkg::NSIDES * W;
    localparam logic [7:0] LIVE_MASK = 8'h77;

    logic [NBYTES-1:0][7:0] bytes_q;
    logic                   addr_ok;

    assign addr_ok = (int'(cfg_addr) < NBYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
        end else if (cfg_we && addr_ok) begin
            bytes_q[cfg_addr] <= cfg_wdata & LIVE_MASK;
        end
    end

    always_comb begin
        cfg_rdata = addr_ok ? bytes_q[cfg_addr] : 8'h00;
    end

    for (genvar n = 0; n < NTRK; n++) begin : g_nib
        assign en[n] = bytes_q[n/2][(n%2)*swbox_pkg::NIB_W +: swbox_pkg::NSRC];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bytes_q == '0));

    // R7
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && addr_ok) |=> (bytes_q[$past(cfg_addr)] == ($past(cfg_wdata) & LIVE_MASK)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(bytes_q));

endmodule

// File: rtl/swbox_track_mux.sv
module swbox_track_mux #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] src,
    output logic            o
);
    always_comb begin
        o = |(en & src);
    end
endmodule

// File: rtl/swbox_wilton.sv
module swbox_wilton #(
    parameter  int W  = 4,
    localparam int NB = 2 * W,
    localparam int AW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic [W-1:0]  trk_in_n,
    input  logic [W-1:0]  trk_in_e,
    input  logic [W-1:0]  trk_in_s,
    input  logic [W-1:0]  trk_in_w,
    output logic [W-1:0]  trk_out_n,
    output logic [W-1:0]  trk_out_e,
    output logic [W-1:0]  trk_out_s,
    output logic [W-1:0]  trk_out_w
);
    import swbox_pkg::*;

    localparam int NTRK = NSIDES * W;

    logic [NSIDES-1:0][W-1:0]   in_bus;
    logic [NSIDES-1:0][W-1:0]   out_bus;
    logic [NTRK-1:0][NSRC-1:0]  en_bus;

    assign in_bus[SIDE_N] = trk_in_n;
    assign in_bus[SIDE_E] = trk_in_e;
    assign in_bus[SIDE_S] = trk_in_s;
    assign in_bus[SIDE_W] = trk_in_w;

    assign trk_out_n = out_bus[SIDE_N];
    assign trk_out_e = out_bus[SIDE_E];
    assign trk_out_s = out_bus[SIDE_S];
    assign trk_out_w = out_bus[SIDE_W];

    swbox_cfg_store #(
        .W      (W),
        .NBYTES (NB),
        .AW     (AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .en        (en_bus)
    );

    for (genvar d = 0; d < NSIDES; d++) begin : g_side
        for (genvar t = 0; t < W; t++) begin : g_trk
            localparam int N  = d * W + t;
            localparam int S0 = src_side(0, d);
            localparam int S1 = src_side(1, d);
            localparam int S2 = src_side(2, d);
            localparam int T0 = src_track(0, t, W);
            localparam int T1 = src_track(1, t, W);
            localparam int T2 = src_track(2, t, W);

            logic [NSRC-1:0] src;
            assign src = {in_bus[S2][T2], in_bus[S1][T1], in_bus[S0][T0]};

            swbox_track_mux #(.NSRC(NSRC)) u_mux (
                .en  (en_bus[N]),
                .src (src),
                .o   (out_bus[d][t])
            );

            // R3
            straight_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en_bus[N][0] && in_bus[S0][T0]) |-> out_bus[d][t]);

            // R4
            cw_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en_bus[N][1] && in_bus[S1][T1]) |-> out_bus[d][t]);

            // R5
            ccw_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en_bus[N][2] && in_bus[S2][T2]) |-> out_bus[d][t]);

            // R6
            idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en_bus[N] == '0) |-> !out_bus[d][t]);
        end
    end

endmodule

// File: tb/swbox_wilton_tb.sv
`timescale 1ns/1ps
module swbox_wilton_tb;
    localparam int W  = 4;
    localparam int NB = 2 * W;
    localparam int AW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic [W-1:0]  in_n = '0, in_e = '0, in_s = '0, in_w = '0;
    logic [W-1:0]  out_n, out_e, out_s, out_w;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     cmp_on = 1'b0;
    string  tag = "R1";
    logic [7:0] mem [NB];

    always #4 clk = ~clk;   // 125 MHz

    swbox_wilton #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .trk_in_n(in_n), .trk_in_e(in_e), .trk_in_s(in_s), .trk_in_w(in_w),
        .trk_out_n(out_n), .trk_out_e(out_e), .trk_out_s(out_s), .trk_out_w(out_w)
    );

    // Reference store: reserved bits 3 and 7 discarded (R7).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NB; a++) mem[a] = 8'h00;
        end else if (cfg_we) begin
            mem[cfg_addr] = cfg_wdata & 8'h77;
        end
    end

    // Forward model: walk every live source and mark where it lands.
    function automatic logic [4*W-1:0] model_out();
        logic [3:0][W-1:0] ins;
        logic [3:0][W-1:0] exp;
        ins = {in_w, in_s, in_e, in_n};
        exp = '0;
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < W; i++) begin
                if (ins[s][i]) begin
                    for (int d = 0; d < 4; d++) begin
                        int dt, k, n;
                        if (d == s) continue;
                        if (d == (s + 2) % 4) begin dt = i; k = 0; end
                        else if (d == (s + 3) % 4) begin dt = (i + 1) % W; k = 1; end
                        else begin dt = (W - i) % W; k = 2; end
                        n = d * W + dt;
                        if (mem[n / 2][(n % 2) * 4 + k]) exp[d][dt] = 1'b1;
                    end
                end
            end
        end
        return exp;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(tag, {out_w, out_s, out_e, out_n}, model_out());
            check("R8 readback", cfg_rdata, mem[cfg_addr]);
        end
    end

    task automatic wr(input int a, input logic [7:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_in(input logic [W-1:0] n, input logic [W-1:0] e,
                          input logic [W-1:0] s, input logic [W-1:0] w);
        in_n = n; in_e = e; in_s = s; in_w = w;
        #1;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: cleared store, outputs dead under any input
        tag = "R1";
        set_in('1, '1, '1, '1);
        for (int a = 0; a < NB; a++) begin
            cfg_addr = AW'(a); #1;
            check("R1 byte", cfg_rdata, 8'h00);
        end
        check("R1 outputs", {out_w, out_s, out_e, out_n}, '0);
        set_in('0, '0, '0, '0);

        // R3 straight south t0 -> north t0
        tag = "R3";
        wr(0, 8'h01);
        set_in('0, '0, 4'b0001, '0);
        check("R3 straight", out_n, 4'b0001);
        // R10 same-cycle propagation, no edge
        tag = "R10";
        set_in('0, '0, 4'b0000, '0);
        check("R10 comb drop", out_n, 4'b0000);
        set_in('0, '0, 4'b0001, '0);
        check("R10 comb rise", out_n, 4'b0001);

        // R4 east t3 wraps to north t0
        tag = "R4";
        wr(0, 8'h02);
        set_in('0, 4'b1000, '0, '0);
        check("R4 turn wrap", out_n, 4'b0001);
        set_in('0, '0, 4'b0001, '0);
        check("R4 straight off", out_n, 4'b0000);

        // R5 west t3 mirrors to north t1 (odd nibble)
        tag = "R5";
        wr(0, 8'h40);
        set_in('0, '0, '0, 4'b1000);
        check("R5 mirror", out_n, 4'b0010);
        wr(0, 8'h04);
        set_in('0, '0, '0, 4'b0001);
        check("R5 t0 self", out_n, 4'b0001);

        // R6 OR of two sources
        tag = "R6";
        wr(0, 8'h03);
        set_in('0, 4'b1000, 4'b0001, '0);
        check("R6 both", out_n, 4'b0001);
        set_in('0, '0, 4'b0001, '0);
        check("R6 one", out_n, 4'b0001);
        set_in('0, '0, '0, '0);
        check("R6 none", out_n, 4'b0000);

        // R2 layout: byte 7 high nibble = west t3, straight from east t3
        tag = "R2";
        wr(7, 8'h10);
        set_in('0, 4'b1000, '0, '0);
        check("R2 layout", out_w, 4'b1000);

        // R7 reserved bits
        tag = "R7";
        wr(5, 8'h88);
        cfg_addr = 3'd5; #1;
        check("R7 reserved", cfg_rdata, 8'h00);
        set_in('1, '1, '1, '1);
        check("R7 south out", out_s, {1'b0, 1'b0, 1'b1, 1'b1} & out_s);

        // R9 write isolation and idle hold
        tag = "R9";
        wr(3, 8'h25);
        wr(4, 8'h52);
        cfg_addr = 3'd3; #1;
        check("R9 neighbour", cfg_rdata, 8'h25);
        @(posedge clk); #1;
        cfg_wdata = 8'hFF; cfg_addr = 3'd3;
        @(posedge clk); #1;
        check("R9 no strobe", cfg_rdata, 8'h25);

        // Random traffic against the model
        tag = "R3 R4 R5 R6";
        for (int c = 0; c < 600; c++) begin
            @(posedge clk); #1;
            cfg_we    = ($urandom % 4) == 0;
            cfg_addr  = AW'($urandom);
            cfg_wdata = 8'($urandom);
            in_n = W'($urandom); in_e = W'($urandom);
            in_s = W'($urandom); in_w = W'($urandom);
        end
        cfg_we = 1'b0;

        // R1 mid-run reset
        tag = "R1";
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        set_in('1, '1, '1, '1);
        check("R1 rerun", {out_w, out_s, out_e, out_n}, '0);
        repeat (2) @(posedge clk);
        #1 cmp_on = 1'b0;
        finish_up();
    end
endmodule